// File: doc/BRIEF.md
# Trigger-Aligned Sample Stream Realigner

This block sits between an acquisition FIFO and the rest of a capture path. Each FIFO word carries eight packed 8-bit samples. The block re-emits the stream so that the first sample of the first output word is the sample at the trigger position. The least significant byte of each word is the earliest sample.

The trigger offset is given in samples and is latched by a one-cycle start pulse before each record. Its upper bits give a count of whole FIFO words to read and throw away, from 0 to 3. Its lower three bits give a byte shift from 0 to 7. With a non-zero shift, each output word is built from two words: the tail of the word held from the previous transfer and the head of the word now arriving. Both sides of the block use a valid/ready handshake. Output backpressure stalls the holding register, so no sample is lost or repeated.

Top module: `trig_realign`

## Requirements
- R1: After reset, and until the first start pulse, in_ready and out_valid are both low.
- R2: A start pulse latches offset. Bits [4:3] are the word-skip count and bits [2:0] are the byte shift. in_ready is low in the start cycle.
- R3: After start, the first skip-count words are accepted with in_ready high, then discarded. No output word comes from them.
- R4: With byte shift 0, each kept input word appears unchanged on out_data. out_valid is high in the cycle after that word is accepted.
- R5: With byte shift s > 0, output lane j (lane 0 = bits [7:0] = earliest sample) is lane j+s of the held word when j+s < 8. Otherwise it is lane j+s-8 of the next word. The first kept word alone produces no output. Each later accepted word produces one output word in the following cycle.
- R6: out_valid never presents a word until all eight of its samples have been accepted from the input.
- R7: While out_valid is high and out_ready is low, out_valid and out_data hold steady. Across a record, every kept sample is delivered exactly once and in order.
- R8: A start pulse in the middle of a record drops the pending output word and the held word. out_valid is low in the cycle after the pulse.
- R9: Changes on offset without a start pulse have no effect on the record in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that latches offset and begins a record |
| offset | input | 5 | Trigger offset in samples: word skip in [4:3], byte shift in [2:0] |
| in_valid | input | 1 | Input word valid |
| in_data | input | 64 | Input word, eight samples, earliest in bits [7:0] |
| in_ready | output | 1 | Block accepts the input word this cycle |
| out_valid | output | 1 | Output word valid |
| out_data | output | 64 | Trigger-aligned output word |
| out_ready | input | 1 | Downstream accepts the output word |

## Verification
The checker assumes that start is a single-cycle pulse and that in_data is stable whenever in_valid is high and in_ready is low. It also takes the offset as meaningful only in the start cycle. The hold and latency properties are therefore disabled in cycles where start is high.

The bench drives start for exactly one cycle and always between input transfers. It updates in_data only after a transfer completes. It changes offset to random values mid-record so that the latched copy, not the port, is shown to govern alignment.

// File: rtl/trig_realign_pkg.sv
package trig_realign_pkg;

  localparam int unsigned SAMPLE_W_DEF = 8;
  localparam int unsigned LANES_DEF    = 8;
  localparam int unsigned MAX_SKIP_DEF = 3;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SKIP  = 2'd1,
    PH_PRIME = 2'd2,
    PH_RUN   = 2'd3
  } phase_t;

  // Upper part of the sample offset: whole words to discard.
  function automatic int unsigned skip_field(input int unsigned ofs, input int unsigned shift_w);
    return ofs >> shift_w;
  endfunction

  // Lower part of the sample offset: byte lanes to rotate.
  function automatic int unsigned shift_field(input int unsigned ofs, input int unsigned shift_w);
    return ofs & ((32'd1 << shift_w) - 32'd1);
  endfunction

  // Source position, in the two-word window, of output lane j.
  function automatic int unsigned window_pos(input int unsigned lane, input int unsigned shift);
    return lane + shift;
  endfunction

endpackage

// File: rtl/rlg_ctrl.sv
module rlg_ctrl
  import trig_realign_pkg::*;
#(
  parameter int unsigned SKIP_W  = 2,
  parameter int unsigned SHIFT_W = 3,
  localparam int unsigned OFS_W  = SKIP_W + SHIFT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [OFS_W-1:0]   offset,
  input  logic               in_valid,
  input  logic               slot_free,
  output logic               in_ready,
  output logic               emit,
  output logic               load_held,
  output logic               idle,
  output logic               skipping,
  output logic [SHIFT_W-1:0] shift_q,
  output logic [SKIP_W-1:0]  skip_left
);

  phase_t              phase_q;
  logic [SKIP_W-1:0]   skip_in;
  logic [SHIFT_W-1:0]  shift_in;
  logic                accept;

  assign skip_in  = SKIP_W'(skip_field(32'(offset), SHIFT_W));
  assign shift_in = SHIFT_W'(shift_field(32'(offset), SHIFT_W));

  always_comb begin
    in_ready = 1'b0;
    if (!start) begin
      case (phase_q)
        PH_SKIP:  in_ready = 1'b1;
        PH_PRIME: in_ready = 1'b1;
        PH_RUN:   in_ready = slot_free;
        default:  in_ready = 1'b0;
      endcase
    end
  end

  assign accept    = in_valid && in_ready;
  assign emit      = accept && (phase_q == PH_RUN);
  assign load_held = accept && ((phase_q == PH_PRIME) || (phase_q == PH_RUN));
  assign idle      = (phase_q == PH_IDLE);
  assign skipping  = (phase_q == PH_SKIP);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      skip_left <= '0;
      shift_q   <= '0;
    end else if (start) begin
      shift_q   <= shift_in;
      skip_left <= skip_in;
      if (skip_in != '0)
        phase_q <= PH_SKIP;
      else if (shift_in != '0)
        phase_q <= PH_PRIME;
      else
        phase_q <= PH_RUN;
    end else begin
      case (phase_q)
        PH_SKIP: begin
          if (accept) begin
            skip_left <= skip_left - 1'b1;
            if (skip_left == SKIP_W'(1))
              phase_q <= (shift_q != '0) ? PH_PRIME : PH_RUN;
          end
        end
        PH_PRIME: begin
          if (accept) phase_q <= PH_RUN;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rlg_lane_join.sv
module rlg_lane_join #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned LANES    = 8,
  localparam int unsigned SHIFT_W = $clog2(LANES),
  localparam int unsigned WORD_W  = SAMPLE_W * LANES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [WORD_W-1:0]  din,
  output logic [WORD_W-1:0]  joined
);

  logic [WORD_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)
      held_q <= '0;
    else if (load)
      held_q <= din;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [SHIFT_W:0]   pos;
    logic [SHIFT_W-1:0] sel;
    logic               wrap;

    assign pos  = (SHIFT_W+1)'(trig_realign_pkg::window_pos(j, 32'(shift)));
    assign sel  = pos[SHIFT_W-1:0];
    assign wrap = pos[SHIFT_W];

    always_comb begin
      if (shift == '0)
        joined[j*SAMPLE_W +: SAMPLE_W] = din[j*SAMPLE_W +: SAMPLE_W];
      else if (wrap)
        joined[j*SAMPLE_W +: SAMPLE_W] = din[int'(sel)*SAMPLE_W +: SAMPLE_W];
      else
        joined[j*SAMPLE_W +: SAMPLE_W] = held_q[int'(sel)*SAMPLE_W +: SAMPLE_W];
    end
  end

endmodule

// File: rtl/rlg_out_stage.sv
module rlg_out_stage #(
  parameter int unsigned WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              emit,
  input  logic [WORD_W-1:0] data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              slot_free
);

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_data  <= data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/trig_realign.sv
module trig_realign
  import trig_realign_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned LANES    = LANES_DEF,
  parameter int unsigned MAX_SKIP = MAX_SKIP_DEF,
  localparam int unsigned SHIFT_W = $clog2(LANES),
  localparam int unsigned SKIP_W  = $clog2(MAX_SKIP + 1),
  localparam int unsigned OFS_W   = SKIP_W + SHIFT_W,
  localparam int unsigned WORD_W  = SAMPLE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OFS_W-1:0]  offset,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              out_ready
);

  logic               slot_free;
  logic               emit;
  logic               load_held;
  logic               idle;
  logic               skipping;
  logic [SHIFT_W-1:0] shift_q;
  logic [SKIP_W-1:0]  skip_left;
  logic [WORD_W-1:0]  joined;

  rlg_ctrl #(
    .SKIP_W  (SKIP_W),
    .SHIFT_W (SHIFT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .offset    (offset),
    .in_valid  (in_valid),
    .slot_free (slot_free),
    .in_ready  (in_ready),
    .emit      (emit),
    .load_held (load_held),
    .idle      (idle),
    .skipping  (skipping),
    .shift_q   (shift_q),
    .skip_left (skip_left)
  );

  rlg_lane_join #(
    .SAMPLE_W (SAMPLE_W),
    .LANES    (LANES)
  ) u_join (
    .clk    (clk),
    .rst    (rst),
    .load   (load_held),
    .shift  (shift_q),
    .din    (in_data),
    .joined (joined)
  );

  rlg_out_stage #(
    .WORD_W (WORD_W)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .flush     (start),
    .emit      (emit),
    .data      (joined),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .slot_free (slot_free)
  );

endmodule

// File: rtl/trig_realign_chk.sv
module trig_realign_chk #(
  parameter int unsigned WORD_W  = 64,
  parameter int unsigned SHIFT_W = 3,
  parameter int unsigned SKIP_W  = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [WORD_W-1:0]  out_data,
  input logic               idle,
  input logic               skipping,
  input logic               emit,
  input logic [SHIFT_W-1:0] shift_q,
  input logic [SKIP_W-1:0]  skip_left
);

  a_r1_idle_closed: assert property (@(posedge clk) disable iff (rst)
    idle |-> (!in_ready && !out_valid));

  a_r2_start_blocks_input: assert property (@(posedge clk) disable iff (rst)
    start |-> !in_ready);

  a_r3_ready_while_skipping: assert property (@(posedge clk) disable iff (rst)
    (skipping && !start) |-> in_ready);

  a_r3_silent_while_skipping: assert property (@(posedge clk) disable iff (rst)
    skipping |-> !out_valid);

  a_r3_skip_progress: assert property (@(posedge clk) disable iff (rst)
    (skipping && in_valid && !start && skip_left > SKIP_W'(1)) |=> skipping);

  a_r4_one_cycle_latency: assert property (@(posedge clk) disable iff (rst)
    (emit && !start) |=> out_valid);

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data)));

  a_r8_flush_output: assert property (@(posedge clk) disable iff (rst)
    start |=> !out_valid);

  a_r9_shift_held: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(shift_q));

endmodule

bind trig_realign trig_realign_chk #(
  .WORD_W  (WORD_W),
  .SHIFT_W (SHIFT_W),
  .SKIP_W  (SKIP_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .idle      (idle),
  .skipping  (skipping),
  .emit      (emit),
  .shift_q   (shift_q),
  .skip_left (skip_left)
);

// File: tb/test_trig_realign.sv
module test_trig_realign;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  offset = '0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_ready = 1'b0;

  always #4 clk = ~clk;

  trig_realign i_trig_realign (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .offset    (offset),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference state: byte queue of kept samples not yet delivered.
  logic [7:0] q[$];
  int  drop = 0;
  bit  started = 1'b0;
  bit  expect_out = 1'b0;
  bit  prev_stall = 1'b0;
  bit  after_start = 1'b0;
  int  cur_shift = 0;
  int  sample_ctr = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h time=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit in_fire, out_fire, pushed;
      logic [63:0] exp;
      in_fire  = in_valid && in_ready;
      out_fire = out_valid && out_ready;

      if (!started) begin
        chk(!in_ready && !out_valid, "R1", {62'd0, in_ready, out_valid}, 64'd0);
      end
      if (after_start) chk(!out_valid, "R8", {63'd0, out_valid}, 64'd0);
      if (start) chk(!in_ready, "R2", {63'd0, in_ready}, 64'd0);
      if (expect_out) chk(out_valid, (cur_shift == 0) ? "R4" : "R5", {63'd0, out_valid}, 64'd1);
      if (prev_stall) chk(out_valid, "R7", {63'd0, out_valid}, 64'd1);
      if (started && drop >= 8 && !start) chk(in_ready, "R3", {63'd0, in_ready}, 64'd1);

      if (out_valid) begin
        if (q.size() < 8) begin
          chk(1'b0, "R6", {63'd0, out_valid}, 64'd0);
        end else begin
          for (int j = 0; j < 8; j++) exp[j*8 +: 8] = q[j];
          chk(out_data == exp, (cur_shift == 0) ? "R2 R4 R9" : "R2 R5 R9", out_data, exp);
          if (out_fire) for (int j = 0; j < 8; j++) void'(q.pop_front());
        end
      end

      pushed = 1'b0;
      if (in_fire) begin
        for (int j = 0; j < 8; j++) begin
          if (drop > 0) drop--;
          else begin
            q.push_back(in_data[j*8 +: 8]);
            pushed = 1'b1;
          end
        end
      end
      expect_out  = in_fire && pushed && (q.size() >= 8);
      prev_stall  = out_valid && !out_ready;
      after_start = 1'b0;

      if (start) begin
        q.delete();
        drop        = int'(offset[4:3]) * 8 + int'(offset[2:0]);
        cur_shift   = int'(offset[2:0]);
        started     = 1'b1;
        expect_out  = 1'b0;
        prev_stall  = 1'b0;
        after_start = 1'b1;
      end
    end
  end

  function automatic logic [63:0] make_word(input int base);
    logic [63:0] w;
    for (int j = 0; j < 8; j++) w[j*8 +: 8] = 8'(base + j);
    return w;
  endfunction

  task automatic run_record(input logic [4:0] ofs, input int nwords,
                            input int vpct, input int rpct, input bit drain);
    int sent;
    bit fired;
    @(posedge clk); #1;
    start = 1'b1; offset = ofs; in_valid = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
    offset = 5'($urandom);
    sent = 0;
    in_data = make_word(sample_ctr);
    while (sent < nwords) begin
      in_valid  = (($urandom % 100) < vpct);
      out_ready = (($urandom % 100) < rpct);
      if (($urandom % 4) == 0) offset = 5'($urandom);
      @(negedge clk);
      fired = in_valid && in_ready;
      @(posedge clk); #1;
      if (fired) begin
        sent++;
        sample_ctr += 8;
        in_data = make_word(sample_ctr);
      end
    end
    in_valid = 1'b0;
    if (drain) begin
      out_ready = 1'b1;
      repeat (6) @(posedge clk);
      #1;
      chk(q.size() < 8, "R7", 64'(q.size()), 64'd7);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (4) @(posedge clk);
    for (int k = 0; k < 32; k++) run_record(5'(k), 12, 80, 70, 1'b1);
    run_record(5'b00000, 16, 100, 100, 1'b1);
    run_record(5'b10101, 16, 100, 100, 1'b1);
    run_record(5'b01011, 10, 100, 30, 1'b1);
    run_record(5'b10011, 10, 90, 20, 1'b0);
    run_record(5'b00101, 10, 70, 60, 1'b0);
    run_record(5'b11111, 12, 60, 50, 1'b1);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule